// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Software Refill

This block turns a virtual page number into a physical frame number. It compares the page against every stored entry in parallel. Each entry is tagged with an address-space identifier, so translations that belong to different processes can sit in the buffer together. A lookup takes the current identifier. One cycle later the block returns exactly one outcome: a hit with the physical address, a miss, a page fault, a protection fault or a busy indication.

The block does not walk page tables. After a miss, software or a surrounding controller reads the page-table entry and loads it through the fill port. The fill goes into the least-recently-used slot, or into the slot that already holds the same page and identifier. Two maintenance commands remove entries: an invalidate removes one page of one address space, and a flush clears the whole buffer for context switches that do not rely on identifiers. The reference and modify bits of each entry are updated by successful hits. The response reports their previous values so that the owner of the page table can mirror them.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup matches an entry only when the entry is occupied, its page number equals the page field `lk_vaddr[31:12]` and its identifier equals `lk_asid`. A successful match gives `rsp_hit`, the index of the entry on `rsp_way` and the entry's cacheable bit on `rsp_cache`. All of this appears on the clock edge after the request.
- R2: On a hit, `rsp_paddr` is the stored frame number in bits 31:12, joined to the untranslated offset `lk_vaddr[11:0]`. When there is no hit, `rsp_paddr` is zero.
- R3: A lookup that matches no entry gives `rsp_miss`. This includes a lookup with the right page but a different identifier.
- R4: A lookup that matches an entry whose page-present bit was filled as 0 gives `rsp_pfault`, and no translation is returned.
- R5: Permission codes are 00 for no access, 01 for read-only, and 10 or 11 for read-write. User lookups (`lk_user`=1) use the user code and kernel lookups use the kernel code. A lookup on a present page gives `rsp_prot` instead of a hit when the selected code is 00, or when the code is 01 and `lk_write`=1.
- R6: `rsp_ref_prev` and `rsp_mod_prev` report the entry's reference and modify bits as they stood before the access. Every hit sets the reference bit, a hit with `lk_write`=1 also sets the modify bit, and a fill clears both bits.
- R7: A fill with a new page and identifier goes into the least-recently-used entry. Every matching lookup and every fill make their entry the most recently used. After reset, entry 0 is least recently used and entry N-1 is most recently used.
- R8: A fill whose page and identifier already match an occupied entry rewrites that entry in place, and every other entry stays untouched.
- R9: `flush_all` empties every entry, so that each later lookup misses until the buffer is filled again.
- R10: `inv_en` empties only the entry that matches both `inv_vpn` and `inv_asid`. An invalidate whose identifier differs has no effect.
- R11: A maintenance command (fill, invalidate or flush) in the same cycle as a lookup takes effect, and the lookup returns `rsp_busy` with no other outcome. When commands coincide, flush wins over invalidate and invalidate wins over fill. The command that loses is dropped.
- R12: `rsp_valid` is high exactly one cycle after each `lk_req`. While it is high exactly one of hit, miss, pfault, prot and busy is set, and while it is low none of them is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address: page field 31:12, offset 11:0 |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is made in user mode |
| lk_asid | input | 6 | Current address-space identifier |
| fill_en | input | 1 | Load an entry |
| fill_vpn | input | 20 | Page number of the entry being loaded |
| fill_asid | input | 6 | Identifier of the entry being loaded |
| fill_pfn | input | 20 | Frame number of the entry being loaded |
| fill_present | input | 1 | Page-present bit of the entry being loaded |
| fill_kperm | input | 2 | Kernel permission code |
| fill_uperm | input | 2 | User permission code |
| fill_cache | input | 1 | Cacheable bit of the entry being loaded |
| inv_en | input | 1 | Invalidate one entry |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_asid | input | 6 | Identifier to invalidate |
| flush_all | input | 1 | Empty every entry |
| rsp_valid | output | 1 | A response is present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_pfault | output | 1 | Matched entry is not present |
| rsp_prot | output | 1 | Permission violation |
| rsp_busy | output | 1 | Lookup yielded to a maintenance command |
| rsp_paddr | output | 32 | Physical address on a hit |
| rsp_way | output | 3 | Index of the matched entry |
| rsp_cache | output | 1 | Cacheable bit of the hit entry |
| rsp_ref_prev | output | 1 | Reference bit before this access |
| rsp_mod_prev | output | 1 | Modify bit before this access |

## Verification
Every lookup result is registered, so it can be read one clock edge after the request. A maintenance command changes the buffer at the edge that ends its own cycle, so a lookup in the next cycle already sees the change. The bench drives each operation in the half cycle after a falling edge. It lets one rising edge pass and then takes the response at the next falling edge, which means every check reads the outcome of exactly the operation that came just before it. Reference, modify and LRU effects can only be seen through later lookups, so they are checked through `rsp_ref_prev`, `rsp_mod_prev` and `rsp_way`.

// File: rtl/tlb_pkg.sv
// Package tlb_pkg
// Shared types for the translation buffer: the permission code and the
// per-entry attribute record. Assumes 2-bit permission codes.
package tlb_pkg;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b10,
        PERM_RWX  = 2'b11
    } perm_t;

    typedef struct packed {
        logic  present;
        perm_t kperm;
        perm_t uperm;
        logic  cache;
        logic  refd;
        logic  modf;
    } ent_attr_t;

    // True when the selected permission code forbids the access.
    function automatic logic perm_denied(input perm_t code, input logic is_write);
        return (code == PERM_NONE) || (is_write && (code == PERM_RO));
    endfunction

endpackage

// File: rtl/tlb_cam.sv
// Module tlb_cam
// Holds the tag side of each entry: occupancy, page number and identifier.
// It compares two keys against all entries in parallel, the lookup key and
// the maintenance key. Assumes the caller never loads a duplicate tag.
module tlb_cam #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [N-1:0]     lk_match,
    input  logic [VPN_W-1:0] mt_vpn,
    input  logic [TAG_W-1:0] mt_tag,
    output logic [N-1:0]     mt_match,
    input  logic [N-1:0]     load_vec,
    input  logic [N-1:0]     kill_vec,
    input  logic             kill_all
);

    logic [VPN_W-1:0] vpn_q  [N];
    logic [TAG_W-1:0] tag_q  [N];
    logic [N-1:0]     live_q;

    for (genvar g = 0; g < N; g++) begin : g_ent
        // Update occupancy and key of one entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q[g] <= 1'b0;
                vpn_q[g]  <= '0;
                tag_q[g]  <= '0;
            end else if (kill_all || kill_vec[g]) begin
                live_q[g] <= 1'b0;
            end else if (load_vec[g]) begin
                live_q[g] <= 1'b1;
                vpn_q[g]  <= mt_vpn;
                tag_q[g]  <= mt_tag;
            end
        end

        // Parallel comparators for both keys.
        assign lk_match[g] = live_q[g] && (vpn_q[g] == lk_vpn) && (tag_q[g] == lk_tag);
        assign mt_match[g] = live_q[g] && (vpn_q[g] == mt_vpn) && (tag_q[g] == mt_tag);
    end

endmodule

// File: rtl/tlb_lru.sv
// Module tlb_lru
// Keeps a full recency order as one rank per entry: rank 0 is the most
// recently used and rank N-1 the least. A touch moves one entry to rank 0
// and ages the entries that were more recent. Assumes ranks stay a permutation.
module tlb_lru #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_way,
    output logic [IW-1:0] victim
);

    localparam logic [IW-1:0] OLDEST = IW'(N - 1);

    logic [IW-1:0] rank_q [N];
    logic [IW-1:0] touch_rank;

    assign touch_rank = rank_q[touch_way];

    for (genvar g = 0; g < N; g++) begin : g_rank
        // Reorder one entry's rank on a touch; reset gives index order.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rank_q[g] <= IW'(N - 1 - g);
            end else if (touch_en) begin
                if (touch_way == IW'(g)) begin
                    rank_q[g] <= '0;
                end else if (rank_q[g] < touch_rank) begin
                    rank_q[g] <= rank_q[g] + 1'b1;
                end
            end
        end
    end

    // Find the entry that holds the oldest rank.
    always_comb begin
        victim = '0;
        for (int i = 0; i < N; i++) begin
            if (rank_q[i] == OLDEST) victim = IW'(i);
        end
    end

endmodule

// File: rtl/tlb_data.sv
// Module tlb_data
// Holds the frame number and attribute record of each entry. One read port
// is addressed by way. Writes are a full load, or a reference/modify mark
// made on a hit. Assumes a load and a mark never target the same cycle.
module tlb_data #(
    parameter int N     = 8,
    parameter int PFN_W = 20,
    parameter int IW    = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IW-1:0]        rd_way,
    output logic [PFN_W-1:0]     rd_pfn,
    output tlb_pkg::ent_attr_t   rd_attr,
    input  logic                 load_en,
    input  logic [IW-1:0]        load_way,
    input  logic [PFN_W-1:0]     load_pfn,
    input  tlb_pkg::ent_attr_t   load_attr,
    input  logic                 mark_en,
    input  logic [IW-1:0]        mark_way,
    input  logic                 mark_mod
);

    logic [PFN_W-1:0]   pfn_q  [N];
    tlb_pkg::ent_attr_t attr_q [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Load or mark one entry's payload.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pfn_q[g]  <= '0;
                attr_q[g] <= '0;
            end else if (load_en && (load_way == IW'(g))) begin
                pfn_q[g]  <= load_pfn;
                attr_q[g] <= load_attr;
            end else if (mark_en && (mark_way == IW'(g))) begin
                attr_q[g].refd <= 1'b1;
                if (mark_mod) attr_q[g].modf <= 1'b1;
            end
        end
    end

    assign rd_pfn  = pfn_q[rd_way];
    assign rd_attr = attr_q[rd_way];

endmodule

// File: rtl/tlb_xlate.sv
// Module tlb_xlate (top)
// Fully associative translation buffer with identifier tags, a software fill
// port, invalidate and flush. It checks permissions and keeps an LRU order.
// A lookup is decoded combinationally and its outcome registered. Any
// maintenance command pre-empts a lookup in the same cycle.
// Assumes one-hot matches, which the in-place refill guarantees.
module tlb_xlate #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int OFF_W = 12,
    parameter int TAG_W = 6,
    localparam int IW   = $clog2(N),
    localparam int VA_W = VPN_W + OFF_W,
    localparam int PA_W = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_user,
    input  logic [TAG_W-1:0] lk_asid,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [TAG_W-1:0] fill_asid,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_present,
    input  logic [1:0]       fill_kperm,
    input  logic [1:0]       fill_uperm,
    input  logic             fill_cache,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic [TAG_W-1:0] inv_asid,
    input  logic             flush_all,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_pfault,
    output logic             rsp_prot,
    output logic             rsp_busy,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [IW-1:0]    rsp_way,
    output logic             rsp_cache,
    output logic             rsp_ref_prev,
    output logic             rsp_mod_prev
);

    import tlb_pkg::*;

    logic [VPN_W-1:0] lk_vpn;
    logic [OFF_W-1:0] lk_off;
    logic [VPN_W-1:0] mt_vpn;
    logic [TAG_W-1:0] mt_tag;
    logic [N-1:0]     lk_match, mt_match;
    logic             lk_any, mt_any;
    logic [IW-1:0]    lk_way, mt_way, victim, fill_way;
    logic             maint_busy, do_look;
    logic             do_flush, do_inv, do_fill;
    logic [N-1:0]     load_vec, kill_vec;
    logic [PFN_W-1:0] hit_pfn;
    ent_attr_t        hit_attr, new_attr;
    perm_t            sel_perm;
    logic             is_pfault, is_prot, is_good;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];

    // Command arbitration: flush over invalidate over fill.
    assign maint_busy = fill_en || inv_en || flush_all;
    assign do_flush   = flush_all;
    assign do_inv     = inv_en && !flush_all;
    assign do_fill    = fill_en && !flush_all && !inv_en;
    assign do_look    = lk_req && !maint_busy;

    assign mt_vpn = inv_en ? inv_vpn  : fill_vpn;
    assign mt_tag = inv_en ? inv_asid : fill_asid;

    tlb_cam #(.N(N), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (lk_vpn),
        .lk_tag   (lk_asid),
        .lk_match (lk_match),
        .mt_vpn   (mt_vpn),
        .mt_tag   (mt_tag),
        .mt_match (mt_match),
        .load_vec (load_vec),
        .kill_vec (kill_vec),
        .kill_all (do_flush)
    );

    // Encode the one-hot match vectors into way indices.
    always_comb begin
        lk_way = '0;
        mt_way = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) lk_way = lk_way | IW'(i);
            if (mt_match[i]) mt_way = mt_way | IW'(i);
        end
    end

    assign lk_any   = |lk_match;
    assign mt_any   = |mt_match;
    assign fill_way = mt_any ? mt_way : victim;

    // Decode the fill target and the invalidate target.
    always_comb begin
        load_vec = '0;
        if (do_fill) load_vec[fill_way] = 1'b1;
        kill_vec = do_inv ? mt_match : '0;
    end

    tlb_lru #(.N(N)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (do_fill || (do_look && lk_any)),
        .touch_way (do_fill ? fill_way : lk_way),
        .victim    (victim)
    );

    // Attribute record written by a fill; reference and modify start clear.
    always_comb begin
        new_attr         = '0;
        new_attr.present = fill_present;
        new_attr.kperm   = perm_t'(fill_kperm);
        new_attr.uperm   = perm_t'(fill_uperm);
        new_attr.cache   = fill_cache;
    end

    tlb_data #(.N(N), .PFN_W(PFN_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_way    (lk_way),
        .rd_pfn    (hit_pfn),
        .rd_attr   (hit_attr),
        .load_en   (do_fill),
        .load_way  (fill_way),
        .load_pfn  (fill_pfn),
        .load_attr (new_attr),
        .mark_en   (do_look && is_good),
        .mark_way  (lk_way),
        .mark_mod  (lk_write)
    );

    // Classify a matching lookup: missing page, permission denial or success.
    always_comb begin
        sel_perm  = lk_user ? hit_attr.uperm : hit_attr.kperm;
        is_pfault = lk_any && !hit_attr.present;
        is_prot   = lk_any && hit_attr.present && perm_denied(sel_perm, lk_write);
        is_good   = lk_any && hit_attr.present && !perm_denied(sel_perm, lk_write);
    end

    // Register the outcome of each lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_pfault   <= 1'b0;
            rsp_prot     <= 1'b0;
            rsp_busy     <= 1'b0;
            rsp_paddr    <= '0;
            rsp_way      <= '0;
            rsp_cache    <= 1'b0;
            rsp_ref_prev <= 1'b0;
            rsp_mod_prev <= 1'b0;
        end else begin
            rsp_valid    <= lk_req;
            rsp_busy     <= lk_req && maint_busy;
            rsp_miss     <= do_look && !lk_any;
            rsp_pfault   <= do_look && is_pfault;
            rsp_prot     <= do_look && is_prot;
            rsp_hit      <= do_look && is_good;
            rsp_paddr    <= (do_look && is_good) ? {hit_pfn, lk_off} : '0;
            rsp_way      <= (do_look && lk_any) ? lk_way : '0;
            rsp_cache    <= do_look && is_good && hit_attr.cache;
            rsp_ref_prev <= do_look && is_good && hit_attr.refd;
            rsp_mod_prev <= do_look && is_good && hit_attr.modf;
        end
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
// Module tlb_xlate_chk
// Port-level properties of tlb_xlate, attached with a bind statement.
module tlb_xlate_chk #(
    parameter int VA_W = 32,
    parameter int PA_W = 32,
    parameter int OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_req,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            fill_en,
    input logic            inv_en,
    input logic            flush_all,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_pfault,
    input logic            rsp_prot,
    input logic            rsp_busy,
    input logic [PA_W-1:0] rsp_paddr
);

    logic [4:0] flags;
    assign flags = {rsp_hit, rsp_miss, rsp_pfault, rsp_prot, rsp_busy};

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones(flags) == 1);                              // R12
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> flags == 5'b0);                                      // R12
    AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rsp_valid == $past(lk_req));                       // R12
    AST_BUSY_ON_MAINT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lk_req && (fill_en || inv_en || flush_all))) |-> rsp_busy); // R11
    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));    // R2
    AST_ZERO_ADDR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_paddr == '0);                                      // R2
    AST_MISS_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(flush_all, 2) && $past(lk_req)
         && !$past(fill_en || inv_en || flush_all)) |-> rsp_miss);          // R9

endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_req     (lk_req),
    .lk_vaddr   (lk_vaddr),
    .fill_en    (fill_en),
    .inv_en     (inv_en),
    .flush_all  (flush_all),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_pfault (rsp_pfault),
    .rsp_prot   (rsp_prot),
    .rsp_busy   (rsp_busy),
    .rsp_paddr  (rsp_paddr)
);

// File: tb/tlb_xlate_tb_top.sv
// Bench for tlb_xlate: sweeps fills, lookups, permissions and maintenance
// against expected values worked out from the requirements.
module tlb_xlate_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 0, lk_write = 0, lk_user = 0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_asid = '0;
    logic        fill_en = 0, fill_present = 0, fill_cache = 0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic [5:0]  fill_asid = '0;
    logic [1:0]  fill_kperm = '0, fill_uperm = '0;
    logic        inv_en = 0, flush_all = 0;
    logic [19:0] inv_vpn = '0;
    logic [5:0]  inv_asid = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_pfault, rsp_prot, rsp_busy;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_way;
    logic        rsp_cache, rsp_ref_prev, rsp_mod_prev;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlate dut_i (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    function automatic logic [11:0] off_of(input logic [19:0] vpn);
        return 12'((vpn * 37 + 5) & 12'hFFF);
    endfunction

    task automatic set_look(input logic [19:0] vpn, input logic [5:0] asid,
                            input bit w, input bit u);
        lk_req = 1; lk_vaddr = {vpn, off_of(vpn)}; lk_asid = asid;
        lk_write = w; lk_user = u;
    endtask

    task automatic set_fill(input logic [19:0] vpn, input logic [5:0] asid,
                            input logic [19:0] pfn, input bit pres,
                            input logic [1:0] kp, input logic [1:0] up, input bit c);
        fill_en = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
        fill_present = pres; fill_kperm = kp; fill_uperm = up; fill_cache = c;
    endtask

    task automatic set_inv(input logic [19:0] vpn, input logic [5:0] asid);
        inv_en = 1; inv_vpn = vpn; inv_asid = asid;
    endtask

    // One cycle: inputs set before the rising edge, outputs read at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        lk_req = 0; fill_en = 0; inv_en = 0; flush_all = 0;
    endtask

    task automatic look(input logic [19:0] vpn, input logic [5:0] asid,
                        input bit w, input bit u);
        set_look(vpn, asid, w, u);
        step();
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn);
        set_fill(vpn, 6'd3, pfn, 1'b1, 2'b10, 2'b10, 1'b0);
        step();
    endtask

    task automatic expect_hit(input logic [19:0] vpn, input logic [19:0] pfn,
                              input int way, input string req);
        look(vpn, 6'd3, 0, 0);
        chk(rsp_hit === 1'b1, req, rsp_hit, 1);
        chk(rsp_paddr === {pfn, off_of(vpn)}, req, rsp_paddr, {pfn, off_of(vpn)});
        if (way >= 0) chk(rsp_way === 3'(way), req, rsp_way, way);
    endtask

    task automatic expect_miss(input logic [19:0] vpn, input logic [5:0] asid, input string req);
        look(vpn, asid, 0, 0);
        chk(rsp_miss === 1'b1 && rsp_hit === 1'b0, req, rsp_miss, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state: no response flags.
        chk(rsp_valid === 0 && rsp_hit === 0 && rsp_miss === 0, "R12", rsp_valid, 0);
        expect_miss(20'h5, 6'd3, "R3");
        chk(rsp_valid === 1'b1, "R12", rsp_valid, 1);
        @(negedge clk);
        chk(rsp_valid === 0 && rsp_miss === 0, "R12", rsp_valid, 0);

        // R7: fills after reset land in index order.
        for (int i = 0; i < 8; i++) begin
            set_fill(20'h100 + 20'(i), 6'd3, 20'h800 + 20'(i * 3), 1'b1, 2'b10, 2'b10, i[0]);
            step();
        end
        // R1 / R2: sweep every entry.
        for (int i = 0; i < 8; i++) begin
            look(20'h100 + 20'(i), 6'd3, 0, 0);
            chk(rsp_hit === 1 && rsp_way === 3'(i), "R1", rsp_way, i);
            chk(rsp_paddr === {20'h800 + 20'(i * 3), off_of(20'h100 + 20'(i))}, "R2",
                rsp_paddr, {20'h800 + 20'(i * 3), off_of(20'h100 + 20'(i))});
            chk(rsp_cache === i[0], "R1", rsp_cache, i[0]);
            chk(rsp_ref_prev === 0, "R6", rsp_ref_prev, 0);
        end
        expect_miss(20'h100, 6'd4, "R3");

        // R7: touching entry 0 makes entry 1 the victim.
        expect_hit(20'h100, 20'h800, 0, "R7");
        fill(20'h200, 20'hAAAAA);
        expect_hit(20'h200, 20'hAAAAA, 1, "R7");
        expect_miss(20'h101, 6'd3, "R7");

        // R8: fill of a resident page rewrites its entry.
        fill(20'h102, 20'h12345);
        expect_hit(20'h102, 20'h12345, 2, "R8");
        expect_hit(20'h103, 20'h809, 3, "R8");

        // R5: full sweep of permission codes, access kinds and modes.
        for (int k = 0; k < 4; k++) begin
            for (int u = 0; u < 4; u++) begin
                set_fill(20'h300, 6'd3, 20'h40000 + 20'(k * 4 + u), 1'b1, 2'(k), 2'(u), 1'b0);
                step();
                for (int m = 0; m < 4; m++) begin
                    automatic int sel = m[1] ? u : k;
                    automatic bit deny = (sel == 0) || (m[0] && sel == 1);
                    look(20'h300, 6'd3, m[0], m[1]);
                    chk(rsp_prot === deny && rsp_hit === !deny, "R5", rsp_prot, deny);
                    if (!deny)
                        chk(rsp_paddr[31:12] === 20'h40000 + 20'(k * 4 + u), "R5",
                            rsp_paddr[31:12], 20'h40000 + 20'(k * 4 + u));
                end
            end
        end
        chk(rsp_way === 3'd4, "R7", rsp_way, 4);
        expect_miss(20'h104, 6'd3, "R7");

        // R4: page marked not present.
        set_fill(20'h301, 6'd3, 20'h1, 1'b0, 2'b10, 2'b10, 1'b0);
        step();
        look(20'h301, 6'd3, 0, 0);
        chk(rsp_pfault === 1 && rsp_hit === 0 && rsp_paddr === 0, "R4", rsp_pfault, 1);

        // R6: reference and modify history.
        fill(20'h400, 20'h77);
        look(20'h400, 6'd3, 0, 0);
        chk(rsp_ref_prev === 0 && rsp_mod_prev === 0, "R6", {rsp_ref_prev, rsp_mod_prev}, 0);
        look(20'h400, 6'd3, 0, 0);
        chk(rsp_ref_prev === 1 && rsp_mod_prev === 0, "R6", {rsp_ref_prev, rsp_mod_prev}, 2);
        look(20'h400, 6'd3, 1, 0);
        chk(rsp_mod_prev === 0, "R6", rsp_mod_prev, 0);
        look(20'h400, 6'd3, 0, 0);
        chk(rsp_mod_prev === 1, "R6", rsp_mod_prev, 1);
        fill(20'h400, 20'h77);
        look(20'h400, 6'd3, 0, 0);
        chk(rsp_ref_prev === 0 && rsp_mod_prev === 0, "R6", {rsp_ref_prev, rsp_mod_prev}, 0);

        // R10: invalidate is selective by page and identifier.
        set_inv(20'h100, 6'd5);
        step();
        expect_hit(20'h100, 20'h800, 0, "R10");
        set_inv(20'h400, 6'd3);
        step();
        expect_miss(20'h400, 6'd3, "R10");
        expect_hit(20'h103, 20'h809, 3, "R10");

        // R11: lookup coinciding with a fill yields busy; the fill lands.
        set_fill(20'h500, 6'd3, 20'h55, 1'b1, 2'b10, 2'b10, 1'b0);
        set_look(20'h500, 6'd3, 0, 0);
        step();
        chk(rsp_busy === 1 && rsp_hit === 0 && rsp_miss === 0, "R11", rsp_busy, 1);
        expect_hit(20'h500, 20'h55, -1, "R11");
        // R11: invalidate beats fill.
        set_inv(20'h100, 6'd3);
        set_fill(20'h600, 6'd3, 20'h66, 1'b1, 2'b10, 2'b10, 1'b0);
        step();
        expect_miss(20'h100, 6'd3, "R11");
        expect_miss(20'h600, 6'd3, "R11");

        // R9: flush with a concurrent lookup, then everything misses.
        flush_all = 1;
        set_look(20'h103, 6'd3, 0, 0);
        step();
        chk(rsp_busy === 1, "R11", rsp_busy, 1);
        expect_miss(20'h103, 6'd3, "R9");
        expect_miss(20'h200, 6'd3, "R9");
        expect_miss(20'h102, 6'd3, "R9");
        expect_miss(20'h500, 6'd3, "R9");
        fill(20'h700, 20'h7007);
        expect_hit(20'h700, 20'h7007, -1, "R9");

        finish_run();
    end

endmodule